// File: doc/BRIEF.md
# CAN Transmit Slot Scheduler

This block manages three transmit slots that sit in front of a CAN protocol engine and decides which waiting frame the engine sends next. Software fills a slot by presenting an identifier, a payload descriptor and a slot index on the add port. It can withdraw a slot through the cancel port. A configuration input chooses between two orderings. In arrival order, slots go out in the sequence they were filled. In identifier order, the waiting slot with the smallest identifier goes first.

The engine side uses a plain request/grant/done handshake. The scheduler raises a request that carries the chosen slot, its identifier and its descriptor. A grant moves that slot to in-flight. A later done pulse, together with an ok flag, closes the transfer. Each successful transfer is logged into a four-entry event queue as a pair: the identifier and a 16-bit timestamp. The timestamp is taken from a free-running counter. If the queue is full when a new event arrives, the new event is dropped and a sticky loss flag is set.

The reset input is asynchronous and active low. The reset tree is expected to release it in step with the clock.

Top module: `can_txsched`

## Requirements
- R1: Adding to an idle slot (index 0 to 2) marks it used in `slot_used` from the next cycle. While no frame is in flight and at least one slot waits, `core_req` is high and `core_slot`, `core_id` and `core_desc` present one waiting slot with the identifier and descriptor that were stored on add.
- R2: An add to a slot that is already used, or to an index of 3 or more, changes nothing. `add_err` is high for exactly the one cycle after that request's clock edge. `add_err` stays low after an accepted add.
- R3: With `cfg_queue_mode` = 1, the offered slot is the waiting slot with the numerically smallest identifier. When two identifiers are equal, the lower slot index wins.
- R4: With `cfg_queue_mode` = 0, waiting slots are offered in the order they were added. A cancelled slot is skipped, and the slots behind it move up.
- R5: A grant while `core_req` is high moves the offered slot to in-flight. `core_req` is low from the next cycle until that transfer's done pulse.
- R6: Cancelling a waiting slot frees it: its `slot_used` bit is 0 from the next cycle and it is never offered.
- R7: Cancelling an in-flight slot is held until done arrives. If done arrives with `core_ok` = 0, the slot is freed with no event. If done arrives with `core_ok` = 1, the slot completes and logs an event. A done with `core_ok` = 0 and no cancel returns the slot to waiting, and it keeps its place in the order.
- R8: A done with `core_ok` = 1 records the in-flight identifier together with the timestamp counter value of the done cycle. The counter reads 0 in the first cycle after reset and advances by 1 each clock. The record is visible on `ev_valid`/`ev_id`/`ev_ts` in the following cycle.
- R9: The event queue holds four records and returns them oldest first. A cycle with `ev_pop` high and `ev_valid` high removes the head.
- R10: A record that arrives while four are held is dropped. `ev_lost` goes high and stays high until reset.
- R11: After reset, `slot_used` = 0 and `core_req`, `ev_valid`, `ev_lost` and `add_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_queue_mode | input | 1 | 1 = identifier order, 0 = arrival order |
| add_valid | input | 1 | Add request |
| add_slot | input | 2 | Slot index for add |
| add_id | input | 11 | Identifier to store |
| add_desc | input | 8 | Payload descriptor to store |
| add_err | output | 1 | One-cycle pulse for a rejected add |
| cancel_valid | input | 1 | Cancel request |
| cancel_slot | input | 2 | Slot index for cancel |
| slot_used | output | 3 | Per-slot occupancy (waiting or in flight) |
| core_req | output | 1 | A frame is offered to the engine |
| core_slot | output | 2 | Offered slot index |
| core_id | output | 11 | Offered identifier |
| core_desc | output | 8 | Offered descriptor |
| core_grant | input | 1 | Engine accepts the offered frame |
| core_done | input | 1 | Engine finished the in-flight frame |
| core_ok | input | 1 | With done: 1 = sent, 0 = not completed |
| ev_valid | output | 1 | Event queue not empty |
| ev_id | output | 11 | Head event identifier |
| ev_ts | output | 16 | Head event timestamp |
| ev_pop | input | 1 | Remove the head event |
| ev_lost | output | 1 | Sticky: an event was dropped |

## Verification
Each result has a fixed cycle on which it is due, and the bench drives every input just after a falling edge and reads every output at a later falling edge.
- The offer on `core_req`/`core_slot` follows from registered slot state, so it is checked at the falling edge right after the add, cancel, grant or done that changed it. `slot_used` and `add_err` are also due one edge after their request.
- An event record is due one edge after the done pulse. A scoreboard queue is loaded at the moment the bench drives done, using the bench's own cycle count as the expected timestamp.
- A monitor pops the queue at each falling edge where `ev_valid` is high and compares the record. Pops are suspended while the overflow case fills the queue.

// File: rtl/can_txsched_pkg.sv
package can_txsched_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_PEND   = 2'd1,
    SLOT_FLIGHT = 2'd2
  } slot_state_e;
endpackage

// File: rtl/txsched_slots.sv
module txsched_slots
  import can_txsched_pkg::*;
#(
  parameter int N_SLOTS = 3,
  parameter int ID_W    = 11,
  parameter int DESC_W  = 8,
  localparam int SEL_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int RANK_W = SEL_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             add_valid,
  input  logic [SEL_W-1:0]                 add_slot,
  input  logic [ID_W-1:0]                  add_id,
  input  logic [DESC_W-1:0]                add_desc,
  input  logic                             cancel_valid,
  input  logic [SEL_W-1:0]                 cancel_slot,
  input  logic                             grant_fire,
  input  logic [SEL_W-1:0]                 grant_slot,
  input  logic                             done_fire,
  input  logic                             done_ok,
  output logic [N_SLOTS-1:0]               pend_vec,
  output logic [N_SLOTS-1:0]               used_vec,
  output logic [N_SLOTS-1:0]               flight_vec,
  output logic [N_SLOTS-1:0][ID_W-1:0]     id_vec,
  output logic [N_SLOTS-1:0][DESC_W-1:0]   desc_vec,
  output logic [N_SLOTS-1:0][RANK_W-1:0]   rank_vec,
  output logic                             add_err
);

  logic [N_SLOTS-1:0] idle_vec;
  logic [N_SLOTS-1:0] leave;
  logic [N_SLOTS-1:0] take;
  logic [RANK_W-1:0]  add_rank;
  logic               add_err_d;
  logic               add_err_q;

  // Rejected add: no idle slot matches the requested index.
  always_comb begin
    add_err_d = add_valid;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (add_slot == SEL_W'(i) && idle_vec[i]) add_err_d = 1'b0;
    end
  end

  // Arrival position of a new entry = occupants that remain after this cycle.
  always_comb begin
    add_rank = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (used_vec[i] && !leave[i]) add_rank = add_rank + RANK_W'(1);
    end
  end

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    slot_state_e       st_q, st_d;
    logic              cxl_q, cxl_d;
    logic [RANK_W-1:0] rank_q, rank_d, below;
    logic [ID_W-1:0]   id_q;
    logic [DESC_W-1:0] desc_q;
    logic              hit_add, hit_cxl, hit_grant, hit_done;
    logic              leave_i, take_i;

    assign hit_add   = add_valid    && (add_slot    == SEL_W'(i));
    assign hit_cxl   = cancel_valid && (cancel_slot == SEL_W'(i));
    assign hit_grant = grant_fire   && (grant_slot  == SEL_W'(i));
    assign hit_done  = done_fire    && (st_q == SLOT_FLIGHT);

    always_comb begin
      st_d    = st_q;
      cxl_d   = cxl_q;
      leave_i = 1'b0;
      take_i  = 1'b0;
      case (st_q)
        SLOT_IDLE: begin
          if (hit_add) begin
            st_d   = SLOT_PEND;
            take_i = 1'b1;
          end
        end
        SLOT_PEND: begin
          if (hit_grant) begin
            st_d  = SLOT_FLIGHT;
            cxl_d = hit_cxl;
          end else if (hit_cxl) begin
            st_d    = SLOT_IDLE;
            leave_i = 1'b1;
          end
        end
        SLOT_FLIGHT: begin
          if (hit_done) begin
            cxl_d = 1'b0;
            if (done_ok || cxl_q || hit_cxl) begin
              st_d    = SLOT_IDLE;
              leave_i = 1'b1;
            end else begin
              st_d = SLOT_PEND;
            end
          end else if (hit_cxl) begin
            cxl_d = 1'b1;
          end
        end
        default: st_d = SLOT_IDLE;
      endcase
    end

    // Close the gaps left by departing entries older than this one.
    always_comb begin
      below = '0;
      for (int j = 0; j < N_SLOTS; j++) begin
        if (leave[j] && (rank_vec[j] < rank_q)) below = below + RANK_W'(1);
      end
      rank_d = take_i ? add_rank : (rank_q - below);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q   <= SLOT_IDLE;
        cxl_q  <= 1'b0;
        rank_q <= '0;
        id_q   <= '0;
        desc_q <= '0;
      end else begin
        st_q   <= st_d;
        cxl_q  <= cxl_d;
        rank_q <= rank_d;
        if (take_i) begin
          id_q   <= add_id;
          desc_q <= add_desc;
        end
      end
    end

    assign leave[i]      = leave_i;
    assign take[i]       = take_i;
    assign idle_vec[i]   = (st_q == SLOT_IDLE);
    assign pend_vec[i]   = (st_q == SLOT_PEND);
    assign flight_vec[i] = (st_q == SLOT_FLIGHT);
    assign used_vec[i]   = (st_q != SLOT_IDLE);
    assign id_vec[i]     = id_q;
    assign desc_vec[i]   = desc_q;
    assign rank_vec[i]   = rank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) add_err_q <= 1'b0;
    else        add_err_q <= add_err_d;
  end
  assign add_err = add_err_q;

  assert_one_flight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flight_vec));

  assert_err_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    add_err |-> $past(add_valid));

  assert_cancel_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_valid && (int'(cancel_slot) < N_SLOTS) && pend_vec[cancel_slot] && !grant_fire)
    |=> !used_vec[$past(cancel_slot)]);

  assert_add_one_at_a_time_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(take) <= 1);

endmodule

// File: rtl/txsched_pick.sv
module txsched_pick #(
  parameter int N_SLOTS = 3,
  parameter int ID_W    = 11,
  localparam int SEL_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int RANK_W = SEL_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           queue_mode,
  input  logic [N_SLOTS-1:0]             pend_vec,
  input  logic [N_SLOTS-1:0][ID_W-1:0]   id_vec,
  input  logic [N_SLOTS-1:0][RANK_W-1:0] rank_vec,
  output logic                           any_pend,
  output logic [SEL_W-1:0]               pick
);

  logic [ID_W-1:0]   best_id;
  logic [RANK_W-1:0] best_rank;
  logic              better;

  // Scan in index order; strict compare leaves ties on the lower index.
  always_comb begin
    any_pend  = 1'b0;
    pick      = '0;
    best_id   = '0;
    best_rank = '0;
    better    = 1'b0;
    for (int i = 0; i < N_SLOTS; i++) begin
      better = queue_mode ? (id_vec[i] < best_id) : (rank_vec[i] < best_rank);
      if (pend_vec[i] && (!any_pend || better)) begin
        any_pend  = 1'b1;
        pick      = SEL_W'(i);
        best_id   = id_vec[i];
        best_rank = rank_vec[i];
      end
    end
  end

  assert_pick_waiting_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |-> pend_vec[pick]);

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_chk
    assert_queue_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (queue_mode && any_pend && pend_vec[i]) |-> (id_vec[pick] <= id_vec[i]));
    assert_queue_tie_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (queue_mode && any_pend && pend_vec[i] && (id_vec[pick] == id_vec[i]))
      |-> (int'(pick) <= i));
    assert_fifo_oldest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!queue_mode && any_pend && pend_vec[i]) |-> (rank_vec[pick] <= rank_vec[i]));
  end

endmodule

// File: rtl/txsched_evlog.sv
module txsched_evlog #(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 11,
  parameter int TS_W   = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [ID_W-1:0] push_id,
  input  logic [TS_W-1:0] push_ts,
  input  logic            pop,
  output logic            ev_valid,
  output logic [ID_W-1:0] ev_id,
  output logic [TS_W-1:0] ev_ts,
  output logic            ev_lost
);

  logic [DEPTH-1:0][ID_W-1:0] id_mem;
  logic [DEPTH-1:0][TS_W-1:0] ts_mem;
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lost_q, lost_d;
  logic             full, empty, wr_en, rd_en;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_en = push && !full;
  assign rd_en = pop && !empty;

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    cnt_d  = cnt_q;
    lost_d = lost_q | (push & full);
    if (wr_en) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
    if (rd_en) rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
    case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_mem[e] <= '0;
        ts_mem[e] <= '0;
      end else if (wr_en && (wr_q == PTR_W'(e))) begin
        id_mem[e] <= push_id;
        ts_mem[e] <= push_ts;
      end
    end
  end

  assign ev_valid = !empty;
  assign ev_id    = id_mem[rd_q];
  assign ev_ts    = ts_mem[rd_q];
  assign ev_lost  = lost_q;

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  assert_lost_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lost |=> ev_lost);
  assert_drop_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> ev_lost);
  assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);

endmodule

// File: rtl/can_txsched.sv
module can_txsched #(
  parameter int N_SLOTS  = 3,
  parameter int ID_W     = 11,
  parameter int DESC_W   = 8,
  parameter int TS_W     = 16,
  parameter int EV_DEPTH = 4,
  localparam int SEL_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int RANK_W  = SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_queue_mode,
  input  logic               add_valid,
  input  logic [SEL_W-1:0]   add_slot,
  input  logic [ID_W-1:0]    add_id,
  input  logic [DESC_W-1:0]  add_desc,
  output logic               add_err,
  input  logic               cancel_valid,
  input  logic [SEL_W-1:0]   cancel_slot,
  output logic [N_SLOTS-1:0] slot_used,
  output logic               core_req,
  output logic [SEL_W-1:0]   core_slot,
  output logic [ID_W-1:0]    core_id,
  output logic [DESC_W-1:0]  core_desc,
  input  logic               core_grant,
  input  logic               core_done,
  input  logic               core_ok,
  output logic               ev_valid,
  output logic [ID_W-1:0]    ev_id,
  output logic [TS_W-1:0]    ev_ts,
  input  logic               ev_pop,
  output logic               ev_lost
);

  logic [N_SLOTS-1:0]               pend_vec, flight_vec;
  logic [N_SLOTS-1:0][ID_W-1:0]     id_vec;
  logic [N_SLOTS-1:0][DESC_W-1:0]   desc_vec;
  logic [N_SLOTS-1:0][RANK_W-1:0]   rank_vec;
  logic                             any_pend, busy, grant_fire, done_fire, log_push;
  logic [SEL_W-1:0]                 pick;
  logic [ID_W-1:0]                  flight_id;
  logic [TS_W-1:0]                  ts_q, ts_d;

  assign busy       = |flight_vec;
  assign core_req   = any_pend && !busy;
  assign grant_fire = core_req && core_grant;
  assign done_fire  = core_done && busy;
  assign log_push   = done_fire && core_ok;

  assign ts_d = ts_q + TS_W'(1);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_d;
  end

  always_comb begin
    core_id   = '0;
    core_desc = '0;
    flight_id = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (pick == SEL_W'(i)) begin
        core_id   = id_vec[i];
        core_desc = desc_vec[i];
      end
      if (flight_vec[i]) flight_id = id_vec[i];
    end
  end
  assign core_slot = pick;

  txsched_slots #(.N_SLOTS(N_SLOTS), .ID_W(ID_W), .DESC_W(DESC_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .add_valid(add_valid), .add_slot(add_slot), .add_id(add_id), .add_desc(add_desc),
    .cancel_valid(cancel_valid), .cancel_slot(cancel_slot),
    .grant_fire(grant_fire), .grant_slot(pick),
    .done_fire(done_fire), .done_ok(core_ok),
    .pend_vec(pend_vec), .used_vec(slot_used), .flight_vec(flight_vec),
    .id_vec(id_vec), .desc_vec(desc_vec), .rank_vec(rank_vec),
    .add_err(add_err)
  );

  txsched_pick #(.N_SLOTS(N_SLOTS), .ID_W(ID_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .queue_mode(cfg_queue_mode),
    .pend_vec(pend_vec), .id_vec(id_vec), .rank_vec(rank_vec),
    .any_pend(any_pend), .pick(pick)
  );

  txsched_evlog #(.DEPTH(EV_DEPTH), .ID_W(ID_W), .TS_W(TS_W)) u_evlog (
    .clk(clk), .rst_n(rst_n),
    .push(log_push), .push_id(flight_id), .push_ts(ts_q), .pop(ev_pop),
    .ev_valid(ev_valid), .ev_id(ev_id), .ev_ts(ev_ts), .ev_lost(ev_lost)
  );

  assert_grant_quiets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && core_grant) |=> !core_req);
  assert_event_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && core_ok && busy && !ev_valid) |=> ev_valid);
  assert_failed_no_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && !core_ok && !ev_valid) |=> !ev_valid);

endmodule

// File: tb/can_txsched_tb.sv
module can_txsched_tb;
  localparam int N_SLOTS = 3;
  localparam int ID_W    = 11;
  localparam int DESC_W  = 8;
  localparam int TS_W    = 16;

  logic              clk, rst_n, cfg_queue_mode;
  logic              add_valid, cancel_valid, add_err;
  logic [1:0]        add_slot, cancel_slot, core_slot;
  logic [ID_W-1:0]   add_id, core_id, ev_id;
  logic [DESC_W-1:0] add_desc, core_desc;
  logic [N_SLOTS-1:0] slot_used;
  logic              core_req, core_grant, core_done, core_ok;
  logic              ev_valid, ev_pop, ev_lost;
  logic [TS_W-1:0]   ev_ts;

  can_txsched u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_queue_mode(cfg_queue_mode),
    .add_valid(add_valid), .add_slot(add_slot), .add_id(add_id), .add_desc(add_desc),
    .add_err(add_err), .cancel_valid(cancel_valid), .cancel_slot(cancel_slot),
    .slot_used(slot_used), .core_req(core_req), .core_slot(core_slot),
    .core_id(core_id), .core_desc(core_desc), .core_grant(core_grant),
    .core_done(core_done), .core_ok(core_ok), .ev_valid(ev_valid),
    .ev_id(ev_id), .ev_ts(ev_ts), .ev_pop(ev_pop), .ev_lost(ev_lost)
  );

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic [TS_W-1:0] ts;
  } ev_t;

  ev_t               exp_q[$];
  int                n_cmp, n_bad;
  bit                drain_en, finished;
  logic [ID_W-1:0]   model_id   [N_SLOTS];
  logic [DESC_W-1:0] model_desc [N_SLOTS];
  logic [TS_W-1:0]   tb_cycle;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_cycle <= '0;
    else        tb_cycle <= tb_cycle + 16'd1;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops and compares event records against the scoreboard (R8, R9).
  always @(negedge clk) begin
    if (!rst_n) begin
      ev_pop <= 1'b0;
    end else begin
      ev_pop <= 1'b0;
      if (drain_en && ev_valid) begin
        if (exp_q.size() == 0) begin
          check("R8", "unexpected event id", 32'(ev_id), 32'hFFFF_FFFF);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          check("R8", "event id", 32'(ev_id), 32'(e.id));
          check("R8", "event timestamp", 32'(ev_ts), 32'(e.ts));
        end
        ev_pop <= 1'b1;
      end
    end
  end

  task automatic do_add(input int slot, input logic [ID_W-1:0] id,
                        input logic [DESC_W-1:0] desc, input bit accept);
    add_valid = 1'b1; add_slot = 2'(slot); add_id = id; add_desc = desc;
    if (accept) begin model_id[slot] = id; model_desc[slot] = desc; end
    @(negedge clk);
    add_valid = 1'b0;
  endtask

  task automatic do_cancel(input int slot);
    cancel_valid = 1'b1; cancel_slot = 2'(slot);
    @(negedge clk);
    cancel_valid = 1'b0;
  endtask

  task automatic do_grant(input int slot, input string req);
    check(req, "core_req before grant", 32'(core_req), 32'd1);
    check(req, "offered slot", 32'(core_slot), 32'(slot));
    check("R1", "offered id", 32'(core_id), 32'(model_id[slot]));
    core_grant = 1'b1;
    @(negedge clk);
    core_grant = 1'b0;
    check("R5", "core_req while in flight", 32'(core_req), 32'd0);
  endtask

  task automatic do_done(input int slot, input bit ok, input bit logged);
    core_done = 1'b1; core_ok = ok;
    if (logged) exp_q.push_back('{id: model_id[slot], ts: tb_cycle});
    @(negedge clk);
    core_done = 1'b0; core_ok = 1'b0;
  endtask

  task automatic serve(input int slot, input string req);
    do_grant(slot, req);
    do_done(slot, 1'b1, 1'b1);
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cfg_queue_mode = 1'b1; add_valid = 1'b0; cancel_valid = 1'b0;
    add_slot = '0; cancel_slot = '0; add_id = '0; add_desc = '0;
    core_grant = 1'b0; core_done = 1'b0; core_ok = 1'b0;
    drain_en = 1'b1; n_cmp = 0; n_bad = 0; finished = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "slot_used", 32'(slot_used), 32'd0);
    check("R11", "core_req", 32'(core_req), 32'd0);
    check("R11", "ev_valid", 32'(ev_valid), 32'd0);
    check("R11", "ev_lost", 32'(ev_lost), 32'd0);
    check("R11", "add_err", 32'(add_err), 32'd0);

    // R3: identifier order with a tie on 0x120
    do_add(0, 11'h300, 8'hA0, 1'b1);
    do_add(1, 11'h120, 8'hA1, 1'b1);
    do_add(2, 11'h120, 8'hA2, 1'b1);
    check("R1", "slot_used all", 32'(slot_used), 32'h7);
    check("R1", "offered desc", 32'(core_desc), 32'hA1);
    serve(1, "R3");
    serve(2, "R3");
    serve(0, "R3");
    check("R1", "slot_used drained", 32'(slot_used), 32'd0);

    // R4 / R6: arrival order with a cancelled entry
    cfg_queue_mode = 1'b0;
    do_add(2, 11'h600, 8'hB2, 1'b1);
    do_add(0, 11'h700, 8'hB0, 1'b1);
    do_add(1, 11'h050, 8'hB1, 1'b1);
    serve(2, "R4");
    do_cancel(0);
    check("R6", "cancelled slot freed", 32'(slot_used), 32'h2);
    serve(1, "R4");

    // R2: add to occupied slot is rejected
    do_add(1, 11'h111, 8'hC1, 1'b1);
    check("R2", "add_err after accepted add", 32'(add_err), 32'd0);
    do_add(1, 11'h222, 8'hCC, 1'b0);
    check("R2", "add_err after rejected add", 32'(add_err), 32'd1);
    @(negedge clk);
    check("R2", "add_err pulse width", 32'(add_err), 32'd0);
    check("R2", "stored id kept", 32'(core_id), 32'h111);
    serve(1, "R2");

    // R7: cancel while in flight
    wait_drain();
    do_add(0, 11'h0AA, 8'hD0, 1'b1);
    do_grant(0, "R7");
    do_cancel(0);
    check("R7", "in flight still used", 32'(slot_used), 32'h1);
    do_done(0, 1'b0, 1'b0);
    check("R7", "cancelled flight freed", 32'(slot_used), 32'd0);
    check("R7", "no event on failed cancel", 32'(ev_valid), 32'd0);
    do_add(1, 11'h0BB, 8'hD1, 1'b1);
    do_grant(1, "R7");
    do_cancel(1);
    do_done(1, 1'b1, 1'b1);
    check("R7", "completed despite cancel", 32'(slot_used), 32'd0);
    do_add(2, 11'h0CC, 8'hD2, 1'b1);
    do_grant(2, "R7");
    do_done(2, 1'b0, 1'b0);
    check("R7", "retry keeps slot", 32'(slot_used), 32'h4);
    serve(2, "R7");

    // R9 / R10: fill the log and overflow it
    wait_drain();
    drain_en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      do_add(0, 11'(11'h400 + k), 8'hE0, 1'b1);
      do_grant(0, "R9");
      do_done(0, 1'b1, k < 4);
      if (k == 3) check("R9", "ev_lost with four held", 32'(ev_lost), 32'd0);
    end
    check("R10", "ev_lost after drop", 32'(ev_lost), 32'd1);
    drain_en = 1'b1;
    wait_drain();
    @(negedge clk);
    check("R9", "queue empty after drain", 32'(ev_valid), 32'd0);
    check("R10", "ev_lost sticky", 32'(ev_lost), 32'd1);
    check("R8", "scoreboard empty", 32'(exp_q.size()), 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule